// File: doc/BRIEF.md
# Bridge Fault Protection Supervisor

This block watches the fault flags that surround a set of H-bridge output stages and decides, clock by clock, which bridges may drive. Each bridge has its own overcurrent flag. A flag must stay high for a programmable number of clock cycles before it counts. A confirmed overcurrent switches that bridge off for a fixed back-off interval. After the interval the bridge comes back by itself, with no action from outside. A pair of thermal flags (one for "too hot", one for "cooled below the hysteresis point") stops all bridges and releases them only when the cool flag is seen. The internal logic keeps running while this happens.

An undervoltage input works as the block's reset. It acts at once and without a clock: it turns every bridge off, marks the internal logic inactive, and holds a reset toward the command decoder. It is released cleanly two clock cycles after the supply recovers. A low wake input (sleep) leaves every bridge undriven and clears the overcurrent and thermal state. All asynchronous flags pass through a synchronizer first. No output reports which fault is active.

Top module: `bfs_supervisor`

## Requirements
- R1: An overcurrent flag only acts after it has been seen high on DEGLITCH_CYCLES consecutive synchronized samples. A pulse of DEGLITCH_CYCLES-1 cycles leaves `bridge_en` unchanged. With SYNC_STAGES=2, a flag raised ahead of edge E0 and held drops the enable right after edge E(DEGLITCH_CYCLES+1).
- R2: A confirmed overcurrent on bridge i clears only `bridge_en[i]`. Bit i of `bridge_en` belongs to bridge i, and every other bridge keeps driving.
- R3: After an overcurrent shutdown the bridge stays off for exactly RETRY_CYCLES clock cycles and then re-enables with no external action.
- R4: If the overcurrent is still present when the back-off ends, the bridge drives for exactly DEGLITCH_CYCLES cycles (a fresh deglitch window) before it shuts down again.
- R5: A high `ot_hot` (after synchronization) turns all bridges off while `core_active` stays 1. The bridges stay off after `ot_hot` falls, until `ot_cool` is seen high.
- R6: A high `uv_fault` forces `bridge_en` to 0, `core_active` to 0 and `decoder_rst` to 1 without waiting for a clock. It also clears all overcurrent counters, back-off timers and the thermal latch. When `uv_fault` is released ahead of edge E0, `decoder_rst` falls right after edge E1.
- R7: While `sleep_n` is low, all bridges are off and `core_active` is 0, but `decoder_rst` stays 0. Sleep is the state the block comes out of reset in, and a high `sleep_n` resumes operation.
- R8: Sleep clears any pending overcurrent back-off. A bridge that is woken during its back-off drives again without waiting for the rest of RETRY_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| uv_fault | input | 1 | Undervoltage present, active high, asynchronous |
| sleep_n | input | 1 | Wake request; low means sleep |
| oc_flag | input | NUM_BRIDGES | Raw overcurrent flag per bridge |
| ot_hot | input | 1 | Die above thermal trip level |
| ot_cool | input | 1 | Die below trip level minus hysteresis |
| bridge_en | output | NUM_BRIDGES | Drive permission per bridge; 0 means all switches off |
| core_active | output | 1 | Internal logic awake and out of reset |
| decoder_rst | output | 1 | Reset to the command decoder |

## Verification
The bench builds the supervisor with two bridges, DEGLITCH_CYCLES=8 and RETRY_CYCLES=40, instead of the microsecond and millisecond defaults. With these values the exact deglitch edge, the full back-off length and the re-trip after a persistent fault can all be counted cycle by cycle within a short run. Because the back-off is short but still longer than the sleep and undervoltage sequences, the bench can show that those events cut a back-off short. A back-off that simply expired would look different.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic {
    OC_WATCH   = 1'b0,
    OC_BACKOFF = 1'b1
  } oc_state_e;

  // bits needed for a counter that runs 0 .. limit-1
  function automatic int cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // true when a 0-based counter sits on its final count
  function automatic logic is_last(logic [31:0] cnt, int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bfs_oc_guard.sv
module bfs_oc_guard import bfs_pkg::*; #(
  parameter int unsigned DEGLITCH = 100,
  parameter int unsigned RETRY    = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic oc_s,
  output logic hold,
  output logic trip,
  output logic release_ev
);
  localparam int DW = cnt_width(DEGLITCH);
  localparam int RW = cnt_width(RETRY);

  oc_state_e       st;
  logic [DW-1:0]   dcnt;
  logic [RW-1:0]   rcnt;

  assign trip       = (st == OC_WATCH) && oc_s && is_last(32'(dcnt), DEGLITCH);
  assign release_ev = (st == OC_BACKOFF) && is_last(32'(rcnt), RETRY);
  assign hold       = (st == OC_BACKOFF);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st   <= OC_WATCH;
      dcnt <= '0;
      rcnt <= '0;
    end else if (clr) begin
      st   <= OC_WATCH;
      dcnt <= '0;
      rcnt <= '0;
    end else begin
      case (st)
        OC_WATCH: begin
          rcnt <= '0;
          if (trip) begin
            st   <= OC_BACKOFF;
            dcnt <= '0;
          end else if (oc_s) begin
            dcnt <= dcnt + DW'(1);
          end else begin
            dcnt <= '0;
          end
        end
        default: begin
          dcnt <= '0;
          if (release_ev) begin
            st   <= OC_WATCH;
            rcnt <= '0;
          end else begin
            rcnt <= rcnt + RW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bfs_thermal.sv
module bfs_thermal (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hot_s,
  input  logic cool_s,
  output logic latched
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         latched <= 1'b0;
    else if (clr)    latched <= 1'b0;
    else if (hot_s)  latched <= 1'b1;
    else if (cool_s) latched <= 1'b0;
  end
endmodule

// File: rtl/bfs_supervisor.sv
module bfs_supervisor #(
  parameter int unsigned NUM_BRIDGES     = 2,
  parameter int unsigned DEGLITCH_CYCLES = 100,
  parameter int unsigned RETRY_CYCLES    = 50000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic                   clk,
  input  logic                   uv_fault,
  input  logic                   sleep_n,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  input  logic                   ot_hot,
  input  logic                   ot_cool,
  output logic [NUM_BRIDGES-1:0] bridge_en,
  output logic                   core_active,
  output logic                   decoder_rst
);
  localparam int SW = NUM_BRIDGES + 3;

  // undervoltage: immediate assertion, two-edge release
  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or posedge uv_fault) begin
    if (uv_fault) rst_pipe <= 2'b11;
    else          rst_pipe <= {rst_pipe[0], 1'b0};
  end
  assign rst_int = rst_pipe[1];

  // input synchronizers
  logic [SW-1:0]          raw_flags;
  logic [SW-1:0]          syn_flags;
  logic                   awake;
  logic                   cool_s;
  logic                   hot_s;
  logic [NUM_BRIDGES-1:0] oc_sync;

  assign raw_flags = {oc_flag, ot_hot, ot_cool, sleep_n};

  bfs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst_int),
    .d   (raw_flags),
    .q   (syn_flags)
  );

  assign awake   = syn_flags[0];
  assign cool_s  = syn_flags[1];
  assign hot_s   = syn_flags[2];
  assign oc_sync = syn_flags[SW-1:3];

  // per-bridge overcurrent guards
  logic [NUM_BRIDGES-1:0] oc_hold;
  logic [NUM_BRIDGES-1:0] oc_trip;
  logic [NUM_BRIDGES-1:0] oc_release;

  generate
    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
      bfs_oc_guard #(.DEGLITCH(DEGLITCH_CYCLES), .RETRY(RETRY_CYCLES)) u_guard (
        .clk        (clk),
        .rst        (rst_int),
        .clr        (~awake),
        .oc_s       (oc_sync[b]),
        .hold       (oc_hold[b]),
        .trip       (oc_trip[b]),
        .release_ev (oc_release[b])
      );
    end
  endgenerate

  // thermal hysteresis
  logic ot_latched;

  bfs_thermal u_thermal (
    .clk     (clk),
    .rst     (rst_int),
    .clr     (~awake),
    .hot_s   (hot_s),
    .cool_s  (cool_s),
    .latched (ot_latched)
  );

  // output gating
  logic run_ok;
  assign run_ok      = ~rst_int & awake;
  assign core_active = run_ok;
  assign decoder_rst = rst_int;
  assign bridge_en   = (run_ok && !ot_latched) ? ~oc_hold : '0;
endmodule

// File: rtl/bfs_supervisor_chk.sv
module bfs_supervisor_chk #(
  parameter int unsigned NB  = 2,
  parameter int unsigned DEG = 100
) (
  input logic          clk,
  input logic          uv_fault,
  input logic          rst_int,
  input logic          awake,
  input logic          ot_latched,
  input logic [NB-1:0] oc_sync,
  input logic [NB-1:0] oc_trip,
  input logic [NB-1:0] oc_release,
  input logic [NB-1:0] bridge_en,
  input logic          core_active,
  input logic          decoder_rst
);
  // R6: undervoltage dominates every output
  assert_uv_forces_off_R6: assert property (@(posedge clk)
    uv_fault |-> (bridge_en == '0 && decoder_rst && !core_active));

  // R7: sleep leaves bridges undriven and logic inactive
  assert_sleep_off_R7: assert property (@(posedge clk) disable iff (rst_int)
    !awake |-> (bridge_en == '0 && !core_active));

  // R5: thermal latch keeps every bridge off
  assert_thermal_off_R5: assert property (@(posedge clk) disable iff (rst_int)
    ot_latched |-> bridge_en == '0);

  generate
    for (genvar b = 0; b < NB; b++) begin : g_chk
      // R2: a confirmed trip removes the drive on the next cycle
      assert_trip_disables_R2: assert property (@(posedge clk) disable iff (rst_int)
        oc_trip[b] |=> !bridge_en[b]);

      // R3: end of back-off gives the drive back unless something else blocks it
      assert_release_reenables_R3: assert property (@(posedge clk) disable iff (rst_int)
        oc_release[b] |=> (bridge_en[b] || !core_active || ot_latched));

      if (DEG >= 2) begin : g_deg
        // R1: a trip needs the flag held on at least two consecutive samples
        assert_trip_needs_flag_R1: assert property (@(posedge clk) disable iff (rst_int)
          oc_trip[b] |-> (oc_sync[b] && $past(oc_sync[b])));
      end
    end
  endgenerate
endmodule

bind bfs_supervisor bfs_supervisor_chk #(.NB(NUM_BRIDGES), .DEG(DEGLITCH_CYCLES)) u_chk (
  .clk         (clk),
  .uv_fault    (uv_fault),
  .rst_int     (rst_int),
  .awake       (awake),
  .ot_latched  (ot_latched),
  .oc_sync     (oc_sync),
  .oc_trip     (oc_trip),
  .oc_release  (oc_release),
  .bridge_en   (bridge_en),
  .core_active (core_active),
  .decoder_rst (decoder_rst)
);

// File: tb/bfs_supervisor_test.sv
module bfs_supervisor_test;
  localparam int NB    = 2;
  localparam int DEG   = 8;
  localparam int RETRY = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          uv_fault;
  logic          sleep_n;
  logic          ot_hot;
  logic          ot_cool;
  logic [NB-1:0] oc_flag;
  logic [NB-1:0] bridge_en;
  logic          core_active;
  logic          decoder_rst;

  bfs_supervisor #(
    .NUM_BRIDGES(NB), .DEGLITCH_CYCLES(DEG), .RETRY_CYCLES(RETRY), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .uv_fault(uv_fault), .sleep_n(sleep_n), .oc_flag(oc_flag),
    .ot_hot(ot_hot), .ot_cool(ot_cool), .bridge_en(bridge_en),
    .core_active(core_active), .decoder_rst(decoder_rst)
  );

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  typedef struct {
    int            at;
    logic [NB-1:0] en;
    logic          core;
    logic          rst;
    string         tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side: queue an expectation d negedges ahead
  task automatic push(int d, logic [NB-1:0] en, logic core, logic rst, string tag);
    exp_t e;
    e.at = cyc + d; e.en = en; e.core = core; e.rst = rst; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_out(string tag, logic [NB-1:0] en, logic core, logic rst);
    check({tag, " bridge_en"}, 32'(bridge_en), 32'(en));
    check({tag, " core_active"}, 32'(core_active), 32'(core));
    check({tag, " decoder_rst"}, 32'(decoder_rst), 32'(rst));
  endtask

  // monitor side: pop and compare at the due negedge
  exp_t cur;
  always @(negedge clk) begin
    cyc++;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      cur = sb.pop_front();
      if (cur.at < cyc) check({cur.tag, " missed slot"}, 32'(cur.at), 32'(cyc));
      else check_out(cur.tag, cur.en, cur.core, cur.rst);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lo;
    int hi;
    uv_fault = 1'b1; sleep_n = 1'b0; oc_flag = '0; ot_hot = 1'b0; ot_cool = 1'b0;
    step(3);
    check_out("R6 held in undervoltage", 2'b00, 1'b0, 1'b1);

    // R6 release timing, R7 default sleep
    uv_fault = 1'b0;
    push(2, 2'b00, 1'b0, 1'b1, "R6 reset still held after E0");
    push(3, 2'b00, 1'b0, 1'b0, "R6 reset released after E1 R7 asleep");
    step(5);
    check_out("R7 default asleep", 2'b00, 1'b0, 1'b0);

    sleep_n = 1'b1;
    step(5);
    check_out("R7 awake", 2'b11, 1'b1, 1'b0);

    // R1 short pulse is filtered
    oc_flag[0] = 1'b1; step(DEG - 1); oc_flag[0] = 1'b0; step(6);
    check_out("R1 short pulse ignored", 2'b11, 1'b1, 1'b0);

    // R1 R2 exact trip edge, only bridge 0 affected
    oc_flag[0] = 1'b1;
    push(DEG + 2, 2'b11, 1'b1, 1'b0, "R1 on until deglitch completes");
    push(DEG + 3, 2'b10, 1'b1, 1'b0, "R2 only bridge 0 off");
    step(DEG + 3);

    // R3 back-off length, R4 fresh deglitch on persistent fault
    lo = 1;
    for (int k = 0; k < RETRY * 4; k++) begin
      @(negedge clk);
      if (bridge_en[0]) break;
      lo++;
    end
    check("R3 back-off length", 32'(lo), 32'(RETRY));
    hi = 1;
    for (int k = 0; k < DEG * 4; k++) begin
      @(negedge clk);
      if (!bridge_en[0]) break;
      hi++;
    end
    check("R4 re-drive window on persistent fault", 32'(hi), 32'(DEG));
    @(posedge clk); #2;
    oc_flag[0] = 1'b0;
    step(RETRY + 10);
    check_out("R3 automatic recovery", 2'b11, 1'b1, 1'b0);

    // R2 bridge 1 alone
    oc_flag[1] = 1'b1; step(DEG + 6);
    check_out("R2 only bridge 1 off", 2'b01, 1'b1, 1'b0);
    oc_flag[1] = 1'b0; step(RETRY + 6);
    check_out("R3 bridge 1 recovered", 2'b11, 1'b1, 1'b0);

    // R5 thermal hysteresis
    ot_hot = 1'b1; step(5);
    check_out("R5 hot disables, core runs", 2'b00, 1'b1, 1'b0);
    ot_hot = 1'b0; step(5);
    check_out("R5 stays off until cool", 2'b00, 1'b1, 1'b0);
    ot_cool = 1'b1; step(5);
    check_out("R5 cool resumes", 2'b11, 1'b1, 1'b0);
    ot_cool = 1'b0; step(2);

    // R8 sleep cuts a back-off short
    oc_flag[0] = 1'b1; step(DEG + 6);
    check_out("R8 bridge 0 in back-off", 2'b10, 1'b1, 1'b0);
    oc_flag[0] = 1'b0; sleep_n = 1'b0; step(5);
    check_out("R7 sleep all off", 2'b00, 1'b0, 1'b0);
    sleep_n = 1'b1; step(5);
    check_out("R8 back-off cleared by sleep", 2'b11, 1'b1, 1'b0);

    // R6 asynchronous undervoltage clears back-off and thermal latch
    oc_flag[1] = 1'b1; step(DEG + 6);
    check_out("R6 bridge 1 in back-off", 2'b01, 1'b1, 1'b0);
    oc_flag[1] = 1'b0; ot_hot = 1'b1; step(4); ot_hot = 1'b0; step(3);
    check_out("R6 thermal latched before undervoltage", 2'b00, 1'b1, 1'b0);
    @(negedge clk); #3;
    uv_fault = 1'b1;
    #1;
    check_out("R6 immediate off without clock", 2'b00, 1'b0, 1'b1);
    step(3);
    uv_fault = 1'b0;
    step(8);
    check_out("R6 state cleared after undervoltage", 2'b11, 1'b1, 1'b0);

    step(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule